// File: doc/BRIEF.md
# Second-Order Masked Two-Stage Quadratic Substitution

This block evaluates a 4-bit substitution on data split into five Boolean shares. The unshared value is the XOR of the five shares. The substitution is built as a chain of two quadratic bijections with optional affine maps around and between them: S = A3 ∘ QB ∘ A2 ∘ QA ∘ A1. Each quadratic stage works on the five input shares in three steps. First it expands them into ten 4-bit intermediate shares using cross-share component functions. It then stores all ten in a register. After the register it folds them back to five shares by XORing intermediate share k with share k+5. Because the values are held in the register before any folding, no glitchy combination of three or more input shares can reach the next stage.

The affine maps are parameters. Each one is a 4x4 bit matrix plus a 4-bit constant. The matrix is applied to every share, and the constant is added to share 0 only. By default every map is the identity. The block takes a new sharing on every cycle in which the input valid is high. Producing fresh random shares is left to the surrounding logic.

Top module: `masked_sbox2_top`

## Requirements
- R1: While reset is high and in the cycle after it, out_valid is 0. With the default parameters, all twenty bits of out_shares are 0.
- R2: With identity affine maps, an accepted input whose shares XOR to x yields output shares whose XOR is QB(QA(x)). Share k occupies bits [4k+3:4k], and bit 0 of a nibble is its least significant bit. QA maps inputs 0..15 to 0,1,2,3,4,5,6,7,8,9,B,A,E,F,D,C. QB maps inputs 0..15 to 0,1,2,3,4,5,6,7,8,A,C,E,B,9,F,D. This holds for every x and for every sharing of it.
- R3: out_valid goes high exactly two clock edges after the edge at which in_valid was sampled high, and only then.
- R4: Inputs presented on consecutive cycles are all accepted, one result per cycle, with no bubbles.
- R5: A stage register loads only when its valid input is high. When no result arrives, out_shares hold their previous value.
- R6: The affine maps act as parameters. Output bit r of a map is the parity of (input AND row r). Row r is matrix bits [4r+3:4r]. The constant is XORed into share 0 only. The XOR of the output shares equals A3(QB(A2(QA(A1(x))))).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A new input sharing is present |
| in_shares | input | 20 | Five 4-bit input shares, share k at bits [4k+3:4k] |
| out_valid | output | 1 | Output sharing is a new result |
| out_shares | output | 20 | Five 4-bit output shares, same layout as the input |

## Verification
Each accepted sharing produces its result two clock edges later: one edge for the first stage register and one for the second. The bench keeps a two-entry model pipeline that advances once per clock. It compares at the falling edge after each rising edge, so the output it checks is the one due from the entry that has just reached the model's second slot. The bench also knows when the second stage could not have loaded, because no valid was waiting in the first slot. On those cycles it checks that the output shares have not moved since the previous sample. A second instance with non-identity affine maps is checked against its own composed reference in the same cycle.

// File: rtl/msb2_pkg.sv
package msb2_pkg;
  localparam int NB   = 4;
  localparam int NSH  = 5;
  localparam int NEXP = 2 * NSH;
  localparam int SHW  = NSH * NB;
  localparam int EXW  = NEXP * NB;

  typedef logic [NB-1:0] nib_t;
  typedef enum logic {QF_ALPHA, QF_BETA} qkind_e;

  // share index pairs feeding each expanded share; first NSH use f, rest use g
  function automatic int pair_lo(input int k);
    case (k)
      0: return 1; 1: return 2; 2: return 3; 3: return 4; 4: return 0;
      5: return 1; 6: return 2; 7: return 0; 8: return 1; default: return 0;
    endcase
  endfunction

  function automatic int pair_hi(input int k);
    case (k)
      0: return 2; 1: return 3; 2: return 4; 3: return 0; 4: return 1;
      5: return 3; 6: return 4; 7: return 3; 8: return 4; default: return 2;
    endcase
  endfunction

  // cross product term between two shares: d_i x_j ^ x_i d_j
  function automatic logic xt(input logic xi, input logic di, input logic xj, input logic dj);
    return (di & xj) ^ (xi & dj);
  endfunction

  function automatic nib_t comp_f(input qkind_e kind, input nib_t si, input nib_t sj);
    nib_t r;
    logic qa, qb, qc;
    qa = (si[0] & si[3]) ^ xt(si[0], si[3], sj[0], sj[3]);
    qb = (si[1] & si[3]) ^ xt(si[1], si[3], sj[1], sj[3]);
    qc = (si[2] & si[3]) ^ xt(si[2], si[3], sj[2], sj[3]);
    if (kind == QF_ALPHA) begin
      r[0] = si[0] ^ qb;
      r[1] = si[1] ^ qc;
      r[2] = si[2];
      r[3] = si[3];
    end else begin
      r[0] = si[0] ^ qa ^ qc;
      r[1] = si[1] ^ qa ^ qb ^ qc;
      r[2] = si[2] ^ qb ^ qc;
      r[3] = si[3];
    end
    return r;
  endfunction

  function automatic nib_t comp_g(input qkind_e kind, input nib_t si, input nib_t sj);
    nib_t r;
    logic ca, cb, cc;
    ca = xt(si[0], si[3], sj[0], sj[3]);
    cb = xt(si[1], si[3], sj[1], sj[3]);
    cc = xt(si[2], si[3], sj[2], sj[3]);
    if (kind == QF_ALPHA) begin
      r = {2'b00, cc, cb};
    end else begin
      r[0] = ca ^ cc;
      r[1] = ca ^ cb ^ cc;
      r[2] = cb ^ cc;
      r[3] = 1'b0;
    end
    return r;
  endfunction

  // unshared quadratic maps, used by the checkers
  function automatic nib_t quad_ref(input qkind_e kind, input nib_t x);
    nib_t r;
    if (kind == QF_ALPHA) begin
      r = {x[3], x[2], x[1] ^ (x[2] & x[3]), x[0] ^ (x[1] & x[3])};
    end else begin
      r[0] = x[0] ^ (x[0] & x[3]) ^ (x[2] & x[3]);
      r[1] = x[1] ^ (x[0] & x[3]) ^ (x[1] & x[3]) ^ (x[2] & x[3]);
      r[2] = x[2] ^ (x[1] & x[3]) ^ (x[2] & x[3]);
      r[3] = x[3];
    end
    return r;
  endfunction

  function automatic nib_t aff_lin(input logic [NB*NB-1:0] mat, input nib_t x);
    nib_t r;
    for (int b = 0; b < NB; b++) r[b] = ^(x & mat[b*NB +: NB]);
    return r;
  endfunction

  function automatic nib_t xor_sh(input logic [SHW-1:0] v);
    nib_t r;
    r = '0;
    for (int s = 0; s < NSH; s++) r = r ^ v[s*NB +: NB];
    return r;
  endfunction
endpackage

// File: rtl/msb2_affine.sv
module msb2_affine
  import msb2_pkg::*;
#(
  parameter logic [NB*NB-1:0] MAT = 16'h8421,
  parameter logic [NB-1:0]    CST = 4'h0
) (
  input  logic [SHW-1:0] sh_i,
  output logic [SHW-1:0] sh_o
);
  for (genvar s = 0; s < NSH; s++) begin : g_share
    if (s == 0) begin : g_const
      assign sh_o[s*NB +: NB] = aff_lin(MAT, sh_i[s*NB +: NB]) ^ CST;
    end else begin : g_plain
      assign sh_o[s*NB +: NB] = aff_lin(MAT, sh_i[s*NB +: NB]);
    end
  end
endmodule

// File: rtl/msb2_compress.sv
module msb2_compress
  import msb2_pkg::*;
(
  input  logic [EXW-1:0] exp_i,
  output logic [SHW-1:0] sh_o
);
  for (genvar s = 0; s < NSH; s++) begin : g_fold
    assign sh_o[s*NB +: NB] = exp_i[s*NB +: NB] ^ exp_i[(s+NSH)*NB +: NB];
  end
endmodule

// File: rtl/msb2_quad_stage.sv
module msb2_quad_stage
  import msb2_pkg::*;
#(
  parameter qkind_e KIND = QF_ALPHA
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           vld_i,
  input  logic [SHW-1:0] sh_i,
  output logic           vld_o,
  output logic [SHW-1:0] sh_o
);
  logic [EXW-1:0] exp_d;
  logic [EXW-1:0] exp_q;
  logic           vld_q;

  for (genvar k = 0; k < NEXP; k++) begin : g_exp
    localparam int PI = pair_lo(k);
    localparam int PJ = pair_hi(k);
    if (k < NSH) begin : g_f
      assign exp_d[k*NB +: NB] = comp_f(KIND, sh_i[PI*NB +: NB], sh_i[PJ*NB +: NB]);
    end else begin : g_g
      assign exp_d[k*NB +: NB] = comp_g(KIND, sh_i[PI*NB +: NB], sh_i[PJ*NB +: NB]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      exp_q <= '0;
    end else begin
      vld_q <= vld_i;
      if (vld_i) exp_q <= exp_d;
    end
  end

  msb2_compress u_fold (
    .exp_i (exp_q),
    .sh_o  (sh_o)
  );

  assign vld_o = vld_q;

  logic [NB-1:0] in_sum, out_sum;
  assign in_sum  = xor_sh(sh_i);
  assign out_sum = xor_sh(sh_o);

  // R3: stage valid follows its input by one edge
  assert_stage_valid_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (vld_o == $past(vld_i)));

  // R2: folded shares recombine to the unshared quadratic map of the input
  assert_stage_value_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(vld_i)) |-> (out_sum == quad_ref(KIND, $past(in_sum))));

  // R5: no load without valid
  assert_stage_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(vld_i)) |-> $stable(exp_q));
endmodule

// File: rtl/masked_sbox2_top.sv
module masked_sbox2_top
  import msb2_pkg::*;
#(
  parameter logic [NB*NB-1:0] A1_MAT = 16'h8421,
  parameter logic [NB-1:0]    A1_CST = 4'h0,
  parameter logic [NB*NB-1:0] A2_MAT = 16'h8421,
  parameter logic [NB-1:0]    A2_CST = 4'h0,
  parameter logic [NB*NB-1:0] A3_MAT = 16'h8421,
  parameter logic [NB-1:0]    A3_CST = 4'h0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [msb2_pkg::SHW-1:0] in_shares,
  output logic                    out_valid,
  output logic [msb2_pkg::SHW-1:0] out_shares
);
  logic [SHW-1:0] pre_a, post_a, mid_in, post_b;
  logic           vld_a, vld_b;

  msb2_affine #(.MAT(A1_MAT), .CST(A1_CST)) u_aff_in (
    .sh_i (in_shares),
    .sh_o (pre_a)
  );

  msb2_quad_stage #(.KIND(QF_ALPHA)) u_stage_a (
    .clk   (clk),
    .rst   (rst),
    .vld_i (in_valid),
    .sh_i  (pre_a),
    .vld_o (vld_a),
    .sh_o  (post_a)
  );

  msb2_affine #(.MAT(A2_MAT), .CST(A2_CST)) u_aff_mid (
    .sh_i (post_a),
    .sh_o (mid_in)
  );

  msb2_quad_stage #(.KIND(QF_BETA)) u_stage_b (
    .clk   (clk),
    .rst   (rst),
    .vld_i (vld_a),
    .sh_i  (mid_in),
    .vld_o (vld_b),
    .sh_o  (post_b)
  );

  msb2_affine #(.MAT(A3_MAT), .CST(A3_CST)) u_aff_out (
    .sh_i (post_b),
    .sh_o (out_shares)
  );

  assign out_valid = vld_b;

  function automatic nib_t full_ref(input nib_t x);
    nib_t t;
    t = aff_lin(A1_MAT, x) ^ A1_CST;
    t = quad_ref(QF_ALPHA, t);
    t = aff_lin(A2_MAT, t) ^ A2_CST;
    t = quad_ref(QF_BETA, t);
    return aff_lin(A3_MAT, t) ^ A3_CST;
  endfunction

  logic [NB-1:0] top_in_sum, top_out_sum;
  assign top_in_sum  = xor_sh(in_shares);
  assign top_out_sum = xor_sh(out_shares);

  // R3: two-edge latency from accepted input to result
  assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (out_valid == $past(in_valid, 2)));

  // R6: composed map including the affine parameters
  assert_composed_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && out_valid) |-> (top_out_sum == full_ref($past(top_in_sum, 2))));
endmodule

// File: tb/masked_sbox2_top_tb.sv
module masked_sbox2_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] TBL_QA = 64'hCDFEAB9876543210;
  localparam logic [63:0] TBL_QB = 64'hDF9BECA876543210;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [19:0] in_shares = '0;
  logic        out_valid, out_valid_a;
  logic [19:0] out_shares, out_shares_a;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  masked_sbox2_top dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_shares(in_shares),
    .out_valid(out_valid), .out_shares(out_shares)
  );

  // non-identity maps: A1 rows {a^b, b, c^d, d} + 5, A2 identity + 3
  masked_sbox2_top #(
    .A1_MAT(16'h8C23), .A1_CST(4'h5),
    .A2_MAT(16'h8421), .A2_CST(4'h3),
    .A3_MAT(16'h8421), .A3_CST(4'h0)
  ) dut_aff (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_shares(in_shares),
    .out_valid(out_valid_a), .out_shares(out_shares_a)
  );

  function automatic logic [3:0] qa(input logic [3:0] x);
    return TBL_QA[x*4 +: 4];
  endfunction
  function automatic logic [3:0] qb(input logic [3:0] x);
    return TBL_QB[x*4 +: 4];
  endfunction
  function automatic logic [3:0] a1m(input logic [3:0] x);
    return {x[3], x[2] ^ x[3], x[1], x[0] ^ x[1]} ^ 4'h5;
  endfunction
  function automatic logic [3:0] s_id(input logic [3:0] x);
    return qb(qa(x));
  endfunction
  function automatic logic [3:0] s_aff(input logic [3:0] x);
    return qb(qa(a1m(x)) ^ 4'h3);
  endfunction
  function automatic logic [3:0] recomb(input logic [19:0] v);
    return v[3:0] ^ v[7:4] ^ v[11:8] ^ v[15:12] ^ v[19:16];
  endfunction

  task automatic check(input string req, input logic [19:0] act, input logic [19:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // model pipeline
  logic       p1_v = 0, p2_v = 0, cur_v = 0;
  logic [3:0] p1_e = 0, p1_ea = 0, p2_e = 0, p2_ea = 0, cur_x = 0;
  logic [19:0] prev_sh = '0;

  task automatic cycle(input logic v, input logic [3:0] x, input string vreq);
    logic loaded;
    logic [19:0] sh;
    @(negedge clk);
    loaded = p1_v;
    p2_v = p1_v; p2_e = p1_e; p2_ea = p1_ea;
    p1_v = cur_v;
    if (cur_v) begin p1_e = s_id(cur_x); p1_ea = s_aff(cur_x); end
    check(vreq, {19'd0, out_valid}, {19'd0, p2_v});
    check(vreq, {19'd0, out_valid_a}, {19'd0, p2_v});
    if (p2_v) begin
      check("R2", {16'd0, recomb(out_shares)}, {16'd0, p2_e});
      check("R6", {16'd0, recomb(out_shares_a)}, {16'd0, p2_ea});
    end
    if (!loaded) check("R5", out_shares, prev_sh);
    prev_sh = out_shares;
    sh[15:0] = 16'($urandom);
    sh[19:16] = x ^ sh[3:0] ^ sh[7:4] ^ sh[11:8] ^ sh[15:12];
    in_shares = sh;
    in_valid = v;
    cur_v = v;
    cur_x = x;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {19'd0, out_valid}, 20'd0);
    check("R1", out_shares, 20'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", {19'd0, out_valid}, 20'd0);
    check("R1", out_shares, 20'd0);
    prev_sh = out_shares;
    // every input value, several sharings, sparse valid
    for (int rep = 0; rep < 6; rep++) begin
      for (int x = 0; x < 16; x++) begin
        cycle(($urandom % 3) != 0, 4'(x), "R3");
        if (($urandom % 4) == 0) cycle(1'b0, 4'h0, "R3");
      end
    end
    // back-to-back burst
    for (int x = 0; x < 48; x++) cycle(1'b1, 4'(x), "R4");
    // idle tail: outputs must hold
    for (int i = 0; i < 6; i++) cycle(1'b0, 4'h0, "R5");
    // single pulses with gaps
    for (int x = 0; x < 16; x++) begin
      cycle(1'b1, 4'(15 - x), "R3");
      cycle(1'b0, 4'h0, "R3");
      cycle(1'b0, 4'h0, "R3");
    end
    for (int i = 0; i < 3; i++) cycle(1'b0, 4'h0, "R3");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule